// File: doc/BRIEF.md
# Hiccup Soft-Start Fault Sequencer

This block sequences the start-up and fault recovery of a multiphase buck regulator controller. It advances once per PWM switching cycle. A 5-bit voltage identification code selects the target output level in millivolts. After a short start-up delay, a reference code ramps from zero to that target in evenly spread unit steps. The sequencer then holds the reference on the target and follows any later change of the code.

An over-current flag seen while the phases are driving stops the start-up or regulation at once. The phase drivers are released to a high-impedance state, and a much longer dead time follows before another ramp is tried. If the fault is still present when the ramp restarts, the cycle repeats. This limits the average stress on the power stage for as long as the short lasts.

A power-good output compares a digitized output-voltage sample against the programmed level. The comparison has hysteresis and does not latch. Power-good is only ever high in the regulating state.

Top module: `hiccup_seq`

## Requirements
- R1: While `rst` is high, and at the first sample after it is released, `pwm_drive_en` is 0, `ref_mv` is 0 and `pgood` is 0.
- R2: The start-up wait lasts 32 clock cycles. After releasing reset, `pwm_drive_en` first reads 1 after exactly 32 rising edges, and `ref_mv` is 0 at that point.
- R3: Let T be the target and k the number of edges since the ramp began. During the ramp, `ref_mv` equals floor(k*T/2016), so it never falls and rises by at most 1 per cycle. At k = 2016 it equals T, the sequencer enters regulation and `ref_mv` then follows the decoded target one cycle after a code change.
- R4: Code decode for `vid_code` values 0 to 30: target = 1100 + 25*(30 - code) mV. Code 30 (11110) gives 1100 mV and code 0 gives 1850 mV.
- R5: When `oc_flag` is 1 at an edge while ramping or regulating, the outputs after that edge are `pwm_drive_en` = 0, `ref_mv` = 0 and `pgood` = 0, and the fault wait begins.
- R6: The fault wait lasts 2048 cycles, with the drivers tristated throughout. After it, `pwm_drive_en` returns to 1 and a fresh ramp starts from 0. If `oc_flag` is still 1, the next edge enters the fault wait again (hiccup).
- R7: In regulation, `pgood` goes low at the edge where 100*`vsense_mv` < 90*T. It only returns high at the edge where 100*`vsense_mv` >= 93*T. Neither transition latches.
- R8: `pgood` is 0 in every state other than regulation, including the whole fault wait and the ramp.
- R9: Code 31 (11111) means output off. One edge after it appears, `pwm_drive_en`, `ref_mv` and `pgood` are 0, and they stay 0 while the code remains 31. At the first edge with any other code, a 32-cycle start-up wait begins.
- R10: `oc_flag` has no effect during the start-up wait, which still ends after 32 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one edge per switching cycle |
| rst | input | 1 | Synchronous active-high reset |
| vid_code | input | 5 | Voltage identification code (31 = off) |
| oc_flag | input | 1 | Over-current detected |
| vsense_mv | input | 11 | Output voltage sample in mV |
| pwm_drive_en | output | 1 | 1 = drive phases, 0 = tristate |
| ref_mv | output | 11 | Reference code in mV |
| pgood | output | 1 | Power-good |

## Verification
The state register drives all three outputs from the same next-state value. A wrong state or a wrong wait count therefore shows on `pwm_drive_en` in the very cycle it occurs. It appears as a start-up or dead time that is too short or too long, or as a missing re-trigger while the fault persists. A fault in the ramp accumulator shows within one cycle as a `ref_mv` value off the floor(k*T/2016) staircase. A wrong hysteresis state shows on `pgood` at the exact edge the sample crosses either threshold.

// File: rtl/hiccup_seq_pkg.sv
package hiccup_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_START_WAIT,
    ST_RAMP,
    ST_REGULATE,
    ST_FAULT_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    RC_CLEAR,
    RC_STEP,
    RC_TRACK
  } ramp_ctl_t;

endpackage

// File: rtl/hs_vid_decode.sv
module hs_vid_decode #(
  parameter int VID_W   = 5,
  parameter int REF_W   = 11,
  parameter int BASE_MV = 1100,
  parameter int STEP_MV = 25
) (
  input  logic [VID_W-1:0] vid,
  output logic             off,
  output logic [REF_W-1:0] target
);
  localparam int OFF_CODE = (1 << VID_W) - 1;

  int span;

  always_comb begin
    span   = OFF_CODE - 1 - int'(vid);
    off    = (int'(vid) == OFF_CODE);
    target = off ? '0 : REF_W'(BASE_MV + STEP_MV * span);
  end
endmodule

// File: rtl/hs_ramp_gen.sv
module hs_ramp_gen
  import hiccup_seq_pkg::*;
#(
  parameter int REF_W    = 11,
  parameter int RAMP_LEN = 2016
) (
  input  logic             clk,
  input  logic             rst,
  input  ramp_ctl_t        ctl,
  input  logic [REF_W-1:0] target,
  output logic [REF_W-1:0] ref_q
);
  localparam int ACC_W = $clog2(RAMP_LEN) + 1;

  logic [ACC_W-1:0] rem_q;
  logic [REF_W-1:0] tgt_q;
  logic [ACC_W:0]   sum;
  logic             carry;

  // Distributes T unit steps over RAMP_LEN cycles (needs T < RAMP_LEN)
  always_comb begin
    sum   = (ACC_W+1)'(rem_q) + (ACC_W+1)'(tgt_q);
    carry = (sum >= (ACC_W+1)'(RAMP_LEN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      rem_q <= '0;
      tgt_q <= '0;
    end else begin
      case (ctl)
        RC_STEP: begin
          if (carry) begin
            ref_q <= ref_q + 1'b1;
            rem_q <= ACC_W'(sum - (ACC_W+1)'(RAMP_LEN));
          end else begin
            rem_q <= ACC_W'(sum);
          end
        end
        RC_TRACK: begin
          ref_q <= target;
          tgt_q <= target;
          rem_q <= '0;
        end
        default: begin
          ref_q <= '0;
          rem_q <= '0;
          tgt_q <= target;
        end
      endcase
    end
  end

  AST_RAMP_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    ctl == RC_STEP |=> (ref_q == $past(ref_q) || ref_q == $past(ref_q) + 1'b1)); // R3
  AST_RAMP_BELOW_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctl == RC_STEP |-> ref_q <= tgt_q); // R3
endmodule

// File: rtl/hs_pg_monitor.sv
module hs_pg_monitor #(
  parameter int REF_W    = 11,
  parameter int TRIP_PCT = 90,
  parameter int REL_PCT  = 93
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REF_W-1:0] target,
  input  logic [REF_W-1:0] vsense,
  input  logic             regulate_next,
  output logic             pgood_q
);
  localparam int MUL_W = REF_W + 8;

  logic [MUL_W-1:0] vs_scaled, trip_lvl, rel_lvl;
  logic             uv_q, uv_d;

  always_comb begin
    vs_scaled = MUL_W'(vsense) * MUL_W'(100);
    trip_lvl  = MUL_W'(target) * MUL_W'(TRIP_PCT);
    rel_lvl   = MUL_W'(target) * MUL_W'(REL_PCT);
    uv_d      = uv_q ? (vs_scaled < rel_lvl) : (vs_scaled < trip_lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_q    <= 1'b1;
      pgood_q <= 1'b0;
    end else begin
      uv_q    <= uv_d;
      pgood_q <= regulate_next && !uv_d;
    end
  end

  AST_PG_ONLY_REGULATING: assert property (@(posedge clk) disable iff (rst)
    !regulate_next |=> !pgood_q); // R8
  AST_PG_LOW_BELOW_TRIP: assert property (@(posedge clk) disable iff (rst)
    vs_scaled < trip_lvl |=> !pgood_q); // R7
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
  import hiccup_seq_pkg::*;
#(
  parameter int VID_W      = 5,
  parameter int REF_W      = 11,
  parameter int START_WAIT = 32,
  parameter int FAULT_WAIT = 2048,
  parameter int RAMP_LEN   = 2016,
  parameter int BASE_MV    = 1100,
  parameter int STEP_MV    = 25,
  parameter int TRIP_PCT   = 90,
  parameter int REL_PCT    = 93
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VID_W-1:0] vid_code,
  input  logic             oc_flag,
  input  logic [REF_W-1:0] vsense_mv,
  output logic             pwm_drive_en,
  output logic [REF_W-1:0] ref_mv,
  output logic             pgood
);
  localparam int CNT_MAX0 = (FAULT_WAIT > RAMP_LEN) ? FAULT_WAIT : RAMP_LEN;
  localparam int CNT_MAX  = (CNT_MAX0 > START_WAIT) ? CNT_MAX0 : START_WAIT;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             pwm_q;
  logic             vid_off;
  logic [REF_W-1:0] target;
  ramp_ctl_t        ramp_ctl;

  hs_vid_decode #(
    .VID_W(VID_W), .REF_W(REF_W), .BASE_MV(BASE_MV), .STEP_MV(STEP_MV)
  ) u_decode (
    .vid(vid_code), .off(vid_off), .target(target)
  );

  always_comb begin
    state_d = state_q;
    if (vid_off) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:        state_d = ST_START_WAIT;
        ST_START_WAIT: if (cnt_q == CNT_W'(START_WAIT - 1)) state_d = ST_RAMP;
        ST_FAULT_WAIT: if (cnt_q == CNT_W'(FAULT_WAIT - 1)) state_d = ST_RAMP;
        ST_RAMP: begin
          if (oc_flag)                             state_d = ST_FAULT_WAIT;
          else if (cnt_q == CNT_W'(RAMP_LEN - 1))  state_d = ST_REGULATE;
        end
        ST_REGULATE:   if (oc_flag) state_d = ST_FAULT_WAIT;
        default:       state_d = ST_START_WAIT;
      endcase
    end
  end

  always_comb begin
    if (state_d == ST_REGULATE)                          ramp_ctl = RC_TRACK;
    else if (state_d == ST_RAMP && state_q == ST_RAMP)   ramp_ctl = RC_STEP;
    else                                                 ramp_ctl = RC_CLEAR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_START_WAIT;
      cnt_q   <= '0;
      pwm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pwm_q   <= (state_d == ST_RAMP) || (state_d == ST_REGULATE);
      if (state_d != state_q || state_d == ST_OFF || state_d == ST_REGULATE)
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
    end
  end

  hs_ramp_gen #(
    .REF_W(REF_W), .RAMP_LEN(RAMP_LEN)
  ) u_ramp (
    .clk(clk), .rst(rst), .ctl(ramp_ctl), .target(target), .ref_q(ref_mv)
  );

  hs_pg_monitor #(
    .REF_W(REF_W), .TRIP_PCT(TRIP_PCT), .REL_PCT(REL_PCT)
  ) u_pg (
    .clk(clk), .rst(rst), .target(target), .vsense(vsense_mv),
    .regulate_next(state_d == ST_REGULATE), .pgood_q(pgood)
  );

  assign pwm_drive_en = pwm_q;

  AST_OC_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RAMP || state_q == ST_REGULATE) && oc_flag && !vid_off
    |=> state_q == ST_FAULT_WAIT && !pwm_q && !pgood); // R5
  AST_FAULT_TRISTATE: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_FAULT_WAIT |-> !pwm_q && !pgood); // R6
  AST_START_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_START_WAIT |-> !pwm_q); // R2
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    vid_off |=> !pwm_q && !pgood && ref_mv == '0); // R9
  AST_WAIT_IGNORES_OC: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_START_WAIT && oc_flag && !vid_off && cnt_q != CNT_W'(START_WAIT - 1)
    |=> state_q == ST_START_WAIT); // R10
endmodule

// File: tb/hiccup_seq_tb_top.sv
module hiccup_seq_tb_top;
  localparam int RL = 2016;
  localparam int FW = 2048;
  localparam int SW = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  vid;
  logic        oc;
  logic [10:0] vs;
  logic        pwm;
  logic [10:0] refmv;
  logic        pg;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  hiccup_seq dut_i (
    .clk(clk), .rst(rst), .vid_code(vid), .oc_flag(oc), .vsense_mv(vs),
    .pwm_drive_en(pwm), .ref_mv(refmv), .pgood(pg)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pwm(output int n, output bit pg_seen);
    n = 0;
    pg_seen = 0;
    while (!pwm && n < 5000) begin
      step(1);
      n++;
      if (pg) pg_seen = 1;
    end
  endtask

  // Call at the sample where pwm first reads 1 (ramp k = 0)
  task automatic ramp_and_verify(input int t);
    int bad_k = -1;
    int bad_v = 0;
    bit pg_early = 0;
    check(refmv == 0, "R3", "ramp start ref", int'(refmv), 0);
    for (int k = 1; k <= RL; k++) begin
      step(1);
      if (bad_k < 0 && int'(refmv) != (k * t) / RL) begin
        bad_k = k;
        bad_v = int'(refmv);
      end
      if (k < RL && pg) pg_early = 1;
    end
    check(bad_k < 0, "R3", "ramp staircase value", bad_v,
          (bad_k < 0) ? bad_v : (bad_k * t) / RL);
    check(!pg_early, "R8", "pgood during ramp", int'(pg_early), 0);
    check(int'(refmv) == t && pg && pwm, "R3", "ramp end ref", int'(refmv), t);
  endtask

  task automatic t_reset();
    rst = 1'b1; vid = 5'd30; oc = 1'b0; vs = 11'd1100;
    step(3);
    check(!pwm && refmv == 0 && !pg, "R1", "outputs in reset",
          {pwm, pg, refmv}, 0);
  endtask

  task automatic t_startup();
    int n;
    bit s;
    rst = 1'b0;
    step(1);
    check(!pwm && refmv == 0 && !pg, "R1", "first sample after reset",
          {pwm, pg, refmv}, 0);
    wait_pwm(n, s);
    check(n + 1 == SW, "R2", "start-up wait edges", n + 1, SW);
    ramp_and_verify(1100);
  endtask

  task automatic t_vid_sweep();
    int bad = 0;
    int badv = 0;
    vs = 11'd2000;
    for (int v = 0; v <= 30; v++) begin
      vid = 5'(v);
      step(1);
      if (int'(refmv) != 1100 + 25 * (30 - v)) begin
        bad++;
        badv = v;
      end
    end
    check(bad == 0, "R4", "codes decoded wrong, last code", badv, -1);
    vid = 5'd0; step(1);
    check(refmv == 11'd1850, "R4", "code 0", int'(refmv), 1850);
    vid = 5'd30; step(1);
    check(refmv == 11'd1100, "R4", "code 30", int'(refmv), 1100);
    vid = 5'd14; step(1);
    check(refmv == 11'd1500, "R3", "regulate follows code", int'(refmv), 1500);
  endtask

  task automatic t_pgood();
    vs = 11'd1500; step(1);
    check(pg == 1'b1, "R7", "pgood at target", int'(pg), 1);
    vs = 11'd1351; step(1);
    check(pg == 1'b1, "R7", "pgood just above trip", int'(pg), 1);
    vs = 11'd1349; step(1);
    check(pg == 1'b0, "R7", "pgood below trip", int'(pg), 0);
    vs = 11'd1380; step(1);
    check(pg == 1'b0, "R7", "pgood inside hysteresis", int'(pg), 0);
    vs = 11'd1395; step(1);
    check(pg == 1'b1, "R7", "pgood at release level", int'(pg), 1);
    vs = 11'd1500; step(1);
  endtask

  task automatic t_hiccup();
    int n;
    bit s;
    oc = 1'b1; step(1);
    check(!pwm && refmv == 0 && !pg, "R5", "oc in regulate",
          {pwm, pg, refmv}, 0);
    wait_pwm(n, s);
    check(n == FW, "R6", "fault dead time", n, FW);
    check(!s, "R8", "pgood in fault wait", int'(s), 0);
    step(1);
    check(!pwm && refmv == 0, "R6", "retry re-faults", int'(pwm), 0);
    wait_pwm(n, s);
    check(n == FW, "R6", "second dead time", n, FW);
    oc = 1'b0;
    ramp_and_verify(1500);
  endtask

  task automatic t_off_and_abort();
    int n;
    bit s;
    vid = 5'd31; step(1);
    check(!pwm && refmv == 0 && !pg, "R9", "off code", {pwm, pg, refmv}, 0);
    step(40);
    check(!pwm && refmv == 0 && !pg, "R9", "off held", {pwm, pg, refmv}, 0);
    vid = 5'd14; step(1);
    oc = 1'b1; step(1); oc = 1'b0;
    wait_pwm(n, s);
    check(n + 1 == SW, "R10", "start wait with oc pulse", n + 1, SW);
    check(n + 1 == SW, "R9", "restart after off", n + 1, SW);
    step(100);
    oc = 1'b1; step(1); oc = 1'b0;
    check(!pwm && refmv == 0 && !pg, "R5", "oc aborts ramp",
          {pwm, pg, refmv}, 0);
    wait_pwm(n, s);
    check(n == FW, "R6", "dead time after abort", n, FW);
    ramp_and_verify(1500);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_vid_sweep();
    t_pgood();
    t_hiccup();
    t_off_and_abort();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule